// File: doc/BRIEF.md
# Shadowed Configuration Register Bank with Reload

This block holds a small bank of configuration registers. Most of them are paired with a backing copy that models nonvolatile storage as a plain internal array, with no programming delay. A decoded one-byte command stream arrives on a valid/opcode/read-write-flag interface. Commands select the access mode, restore the working registers from the backing copies, or write a data byte to one register.

In register-only mode a data write changes just the working register. In nonvolatile mode the same write also updates the backing copy, so the value survives a later reload. The top register (index 7 by default) stands for a control register such as a timer enable and has no backing copy. A reload leaves it alone. A busy input from a neighbouring timer blocks reloads while the timer is running. Each accepted reload raises a one-cycle done pulse, which the timer may use as its start event.

The working registers are always visible on a flat output bus. Reset stands for power-up: both the backing copies and the working registers take fixed factory values.

Top module: `shadow_reg_bank`

## Requirements
- R1: After reset, each backed register i reads F(i) = ((i*17) XOR 90) truncated to 8 bits. The unbacked register reads 0. The mode is register-only and reload_done is 0. Register i occupies regs_o[8*i+7:8*i].
- R2: An accepted command with cmd_op=1 selects register-only mode when cmd_rw=0 and nonvolatile mode when cmd_rw=1.
- R3: In register-only mode, a write (cmd_op=0) to address a < 8 updates working register a one cycle later and leaves its backing copy unchanged. A later reload shows the old backing value.
- R4: In nonvolatile mode, a write to a backed address updates both the working register and its backing copy. A later reload returns the written value.
- R5: A reload (cmd_op=2) is accepted with either cmd_rw value. All backed working registers take their backing values in the same cycle that reload_done is high, which is the cycle after the command edge.
- R6: A reload presented while timer_busy=1 is ignored: no register changes and reload_done stays 0.
- R7: The unbacked register (index 7) is never changed by a reload. Writes to it update it in both modes.
- R8: reload_done is high for exactly one cycle per accepted reload, and is 0 in all other cycles.
- R9: A write to an address of 8 or above changes no working register and no backing copy, in either mode.
- R10: cmd_op=3 is reserved and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 write, 1 mode select, 2 reload, 3 reserved |
| cmd_rw | input | 1 | Read/write flag; selects the mode for cmd_op=1 |
| cmd_addr | input | 4 | Register address for writes |
| cmd_data | input | 8 | Write data |
| timer_busy | input | 1 | Timer action in progress; blocks reloads |
| regs_o | output | 64 | Working registers, register i at bits 8*i+7:8*i |
| reload_done | output | 1 | One-cycle pulse after an accepted reload |

## Verification
A backing copy that takes a register-only write, or that misses a nonvolatile write, stays invisible until the next reload. The bench therefore follows mode-dependent writes with a reload and compares the whole output bus in the cycle the done pulse is high. A wrong mode bit or a wrong backed-register mask shows on regs_o one cycle after that reload. A blocked reload that leaks through shows as a done pulse and a restored value one cycle after the command.

// File: rtl/shadow_reg_bank.sv
module shadow_reg_bank #(
  parameter int NREG = 8,
  parameter int DW = 8,
  parameter int ADDR_W = 4,
  parameter logic [NREG-1:0] BACKED = 8'h7F
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_valid,
  input  logic [1:0]          cmd_op,
  input  logic                cmd_rw,
  input  logic [ADDR_W-1:0]   cmd_addr,
  input  logic [DW-1:0]       cmd_data,
  input  logic                timer_busy,
  output logic [NREG*DW-1:0]  regs_o,
  output logic                reload_done
);

  localparam logic [1:0] OP_WRITE  = 2'd0;
  localparam logic [1:0] OP_MODE   = 2'd1;
  localparam logic [1:0] OP_RELOAD = 2'd2;

  function automatic logic [DW-1:0] factory(input int i);
    return DW'((i * 17) ^ 90);
  endfunction

  logic [NREG-1:0][DW-1:0] work;
  logic [NREG-1:0][DW-1:0] store;
  logic                    nv_mode;

  wire do_write  = cmd_valid && cmd_op == OP_WRITE;
  wire do_mode   = cmd_valid && cmd_op == OP_MODE;
  wire do_reload = cmd_valid && cmd_op == OP_RELOAD && !timer_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      nv_mode     <= 1'b0;
      reload_done <= 1'b0;
    end else begin
      reload_done <= do_reload;
      if (do_mode) nv_mode <= cmd_rw;
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    wire hit = cmd_addr == ADDR_W'(i);

    if (BACKED[i]) begin : g_backed
      always_ff @(posedge clk) begin
        if (rst) begin
          work[i]  <= factory(i);
          store[i] <= factory(i);
        end else begin
          if (do_reload) work[i] <= store[i];
          else if (do_write && hit) work[i] <= cmd_data;
          if (do_write && hit && nv_mode) store[i] <= cmd_data;
        end
      end

      a_r5_reload_copies: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_RELOAD && !timer_busy) |=> work[i] == $past(store[i]));

      a_r4_write_through: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_WRITE && cmd_addr == ADDR_W'(i) && nv_mode)
        |=> (store[i] == $past(cmd_data) && work[i] == $past(cmd_data)));
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst) work[i] <= '0;
        else if (do_write && hit) work[i] <= cmd_data;
      end
      assign store[i] = '0;

      a_r7_unbacked_keep: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_RELOAD) |=> $stable(work[i]));
    end

    assign regs_o[i*DW +: DW] = work[i];
  end

  a_r3_store_kept: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_WRITE && !nv_mode) |=> $stable(store));

  a_r6_busy_blocks: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_RELOAD && timer_busy) |=> (!reload_done && $stable(work)));

  a_r9_bad_addr: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_WRITE && cmd_addr >= ADDR_W'(NREG))
    |=> ($stable(work) && $stable(store)));

  a_r8_done_cause: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && cmd_op == OP_RELOAD) |=> !reload_done);

endmodule

// File: tb/shadow_reg_bank_tb.sv
`timescale 1ns/1ps
module shadow_reg_bank_tb;
  logic clk = 0, rst = 1;
  logic cmd_valid = 0, cmd_rw = 0, timer_busy = 0;
  logic [1:0] cmd_op = 0;
  logic [3:0] cmd_addr = 0;
  logic [7:0] cmd_data = 0;
  logic [63:0] regs_o;
  logic reload_done;

  int total = 0, bad = 0;
  logic [7:0] mw [8];
  logic [7:0] ms [8];
  logic mnv;
  localparam logic [7:0] BK = 8'h7F;

  always #10 clk = ~clk;

  shadow_reg_bank u_dut (.clk, .rst, .cmd_valid, .cmd_op, .cmd_rw, .cmd_addr,
    .cmd_data, .timer_busy, .regs_o, .reload_done);

  function automatic logic [7:0] fval(int i);
    return 8'((i * 17) ^ 90);
  endfunction

  function automatic logic [63:0] pack_model();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[i*8 +: 8] = mw[i];
    return v;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(logic [1:0] op, logic rw, logic [3:0] a, logic [7:0] d,
                      logic busy, string req);
    logic exp_done;
    exp_done = 0;
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_rw = rw; cmd_addr = a; cmd_data = d;
    timer_busy = busy;
    case (op)
      2'd0: if (a < 8) begin
              mw[a] = d;
              if (mnv && BK[a]) ms[a] = d;
            end
      2'd1: mnv = rw;
      2'd2: if (!busy) begin
              exp_done = 1;
              for (int i = 0; i < 8; i++) if (BK[i]) mw[i] = ms[i];
            end
      default: ;
    endcase
    @(negedge clk);
    cmd_valid = 0; timer_busy = 0;
    check(req, regs_o, pack_model());
    check({req, " done"}, 64'(reload_done), 64'(exp_done));
  endtask

  task automatic idle_done_low(string req);
    @(negedge clk);
    check({req, " pulse width"}, 64'(reload_done), 64'd0);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 8; i++) begin
      mw[i] = BK[i] ? fval(i) : 8'h00;
      ms[i] = mw[i];
    end
    mnv = 0;
    check("R1 reset regs", regs_o, pack_model());
    check("R1 reset done", 64'(reload_done), 64'd0);
  endtask

  task automatic t_reg_mode();
    send(2'd1, 1'b0, 4'd0, 8'h00, 1'b0, "R2 select register-only");
    send(2'd0, 1'b0, 4'd2, 8'hC3, 1'b0, "R3 write reg2");
    send(2'd2, 1'b0, 4'd0, 8'h00, 1'b0, "R3 R5 reload restores reg2");
    check("R3 reg2 back to factory", 64'(regs_o[23:16]), 64'(fval(2)));
    idle_done_low("R8");
  endtask

  task automatic t_nv_mode();
    send(2'd1, 1'b1, 4'd0, 8'h00, 1'b0, "R2 select nonvolatile");
    send(2'd0, 1'b1, 4'd3, 8'h3C, 1'b0, "R4 write reg3");
    send(2'd1, 1'b0, 4'd0, 8'h00, 1'b0, "R2 back to register-only");
    send(2'd0, 1'b0, 4'd3, 8'h00, 1'b0, "R3 overwrite reg3");
    send(2'd2, 1'b1, 4'd0, 8'h00, 1'b0, "R4 R5 reload with rw=1");
    check("R4 reg3 kept written value", 64'(regs_o[31:24]), 64'h3C);
    idle_done_low("R8");
  endtask

  task automatic t_busy();
    send(2'd0, 1'b0, 4'd1, 8'hEE, 1'b0, "R3 write reg1");
    send(2'd2, 1'b0, 4'd0, 8'h00, 1'b1, "R6 reload while busy");
    check("R6 reg1 unchanged", 64'(regs_o[15:8]), 64'hEE);
    send(2'd2, 1'b0, 4'd0, 8'h00, 1'b0, "R6 reload after busy");
    check("R5 reg1 restored", 64'(regs_o[15:8]), 64'(fval(1)));
  endtask

  task automatic t_unbacked();
    send(2'd0, 1'b0, 4'd7, 8'h0F, 1'b0, "R7 write unbacked reg-mode");
    send(2'd1, 1'b1, 4'd0, 8'h00, 1'b0, "R2 nonvolatile");
    send(2'd0, 1'b1, 4'd7, 8'h05, 1'b0, "R7 write unbacked nv-mode");
    send(2'd2, 1'b0, 4'd0, 8'h00, 1'b0, "R7 reload");
    check("R7 unbacked survives reload", 64'(regs_o[63:56]), 64'h05);
  endtask

  task automatic t_bad_addr();
    send(2'd0, 1'b0, 4'd9, 8'hA5, 1'b0, "R9 write addr 9");
    send(2'd0, 1'b0, 4'd15, 8'h5A, 1'b0, "R9 write addr 15");
    send(2'd2, 1'b0, 4'd0, 8'h00, 1'b0, "R9 reload shows store intact");
  endtask

  task automatic t_reserved();
    send(2'd3, 1'b1, 4'd0, 8'hFF, 1'b0, "R10 reserved op");
    send(2'd3, 1'b0, 4'd7, 8'h77, 1'b0, "R10 reserved op again");
  endtask

  task automatic t_back_to_back();
    send(2'd0, 1'b0, 4'd4, 8'h44, 1'b0, "R3 nv-mode write reg4");
    send(2'd2, 1'b0, 4'd0, 8'h00, 1'b0, "R8 first reload");
    send(2'd2, 1'b1, 4'd0, 8'h00, 1'b0, "R8 second reload");
    idle_done_low("R8");
    check("R4 reg4 persisted", 64'(regs_o[39:32]), 64'h44);
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_reg_mode();
    t_nv_mode();
    t_busy();
    t_unbacked();
    t_bad_addr();
    t_reserved();
    t_back_to_back();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule